// File: doc/BRIEF.md
# Word-Mapped Serial Port with Transmit and Receive Queues

This block is a serial port for a 32-bit word bus. Software writes bytes into a 16-entry transmit queue, and a transmitter sends them on `ser_tx` as frames with one start bit, eight data bits (least significant first), no parity and one stop bit. A receiver oversamples `ser_rx` at sixteen times the bit rate and stores each complete byte in a 16-entry receive queue, where software collects it. The line format and bit rate are fixed when the block is built: `CLK_DIV` clocks make one oversample tick, and one bit lasts `16*CLK_DIV` clocks. No register changes the line settings.

Four word registers are decoded from `bus_addr[3:2]`: 0 is receive data, 1 is transmit data, 2 is status and 3 is control. Reads are combinational on `bus_rdata` in the cycle `bus_en` is high, and their side effects take place at the clock edge that ends that cycle. The status word has these fields: bit 7 parity error, which always reads 0 because there is no parity; bit 6 framing error; bit 5 overrun; bit 4 interrupt enable; bit 3 transmit queue full; bit 2 transmit queue empty; bit 1 receive queue full; bit 0 receive data present. A control write uses bit 4 as the interrupt enable, bit 1 to empty the receive queue and bit 0 to empty the transmit queue. The `irq` output is a level signal.

The transmitter state machine has four states. `TX_IDLE` goes to `TX_START` and takes a byte from the queue when the queue is not empty. `TX_START` goes to `TX_DATA` after one bit time. `TX_DATA` goes to `TX_STOP` after the eighth bit. `TX_STOP` goes back to `TX_IDLE` after one bit time. The receiver state machine has five states. `RX_IDLE` goes to `RX_START` when the line is low. `RX_START` goes to `RX_DATA` if the line is still low at mid-bit, and back to `RX_IDLE` if it is not, so that a glitch is rejected. `RX_DATA` goes to `RX_STOP` after eight mid-bit samples. `RX_STOP` delivers the byte at mid-stop. It then goes to `RX_IDLE` if the stop bit was high, or to `RX_WAIT_HIGH` if it was low. `RX_WAIT_HIGH` goes to `RX_IDLE` once the line is high again.

Top module: `serial_port_ctrl`

## Requirements
- R1: After reset the status word reads 0x04, `irq` is low and `ser_tx` is high.
- R2: Word 0 reads receive data, word 1 is written for transmit, word 2 reads status and word 3 takes control writes. A write to the status register has no effect, and a read of word 3 returns zero.
- R3: Each transmitted frame has a low start bit, then bits 0 to 7 of the written word, then a high stop bit. Each bit lasts 16*CLK_DIV clocks, and bytes go out in the order they were written.
- R4: The transmit queue holds 16 bytes. A transmit write while the queue is full is dropped. Status bit 3 shows full and status bit 2 shows empty.
- R5: A received byte, sampled at mid-bit, enters the receive queue. Status bit 0 shows data is present. A read of word 0 returns the oldest byte in bits 7:0 with zeros above it and removes that byte.
- R6: Status bit 1 shows the receive queue is full. A byte that arrives while the queue is full is discarded and sets status bit 5 (overrun).
- R7: A frame whose stop bit is sampled low sets status bit 6 (framing error), and its byte is still stored.
- R8: A read of the status word clears bits 6 and 5. Bit 7 always reads 0.
- R9: A read of word 0 while the receive queue is empty returns zero and leaves the queue unchanged.
- R10: Control bit 1 empties the receive queue and control bit 0 empties the transmit queue. A byte already being sent still finishes.
- R11: Control bit 4 sets the interrupt enable, which reads back as status bit 4.
- R12: `irq` = enable AND (receive data present OR transmit-empty pending). The pending flag sets when the transmit queue goes from non-empty to empty, and clears on a transmit write or a status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_en | input | 1 | Register access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address; bits 3:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_en is high and bus_we is low |
| irq | output | 1 | Level interrupt request |
| ser_rx | input | 1 | Serial input line |
| ser_tx | output | 1 | Serial output line |

## Verification
Assertions check on every cycle that the queue counters neither wrap nor accept a write when full, and that a clear leaves a queue empty. They also check that a byte arriving at a full receive queue raises overrun, that a status read clears the error flags unless a new error arrives in the same cycle, that an empty receive read returns zero, and that `irq` never rises while the enable is clear. Only the bench's scenarios can show the frame timing and bit order on the line, the order of bytes through both queues, the exact byte a dropped write loses, and that a queue clear lets the byte already in flight finish. The bench tracks these with its own queues and flags.

// File: rtl/spc_pkg.sv
package spc_pkg;

    // word index decoded from bus_addr[3:2]
    localparam logic [1:0] WORD_RXDATA = 2'd0;
    localparam logic [1:0] WORD_TXDATA = 2'd1;
    localparam logic [1:0] WORD_STATUS = 2'd2;
    localparam logic [1:0] WORD_CONTROL = 2'd3;

    // control word fields
    localparam int CTL_IE     = 4;
    localparam int CTL_RX_CLR = 1;
    localparam int CTL_TX_CLR = 0;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_STOP
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_WAIT_HIGH
    } rx_state_e;

endpackage

// File: rtl/spc_fifo.sv
module spc_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [AW:0]   cnt_q;
    logic          do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == FULL_CNT);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign rdata   = mem[rp_q];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else if (clr) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= wp_q + 1'b1;
            if (do_pop)  rp_q <= rp_q + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wp_q] <= wdata;
    end

    AST_FIFO_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clr) |=> full);                            // R4
    AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL_CNT);                                                  // R4
    AST_FIFO_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> empty);                                                      // R10

endmodule

// File: rtl/spc_tx.sv
module spc_tx
    import spc_pkg::*;
#(
    parameter int TICKS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       q_empty,
    input  logic [7:0] q_data,
    output logic       q_pop,
    output logic       line
);
    localparam int TCW = $clog2(TICKS);
    localparam logic [TCW-1:0] LAST_TICK = TCW'(TICKS - 1);

    tx_state_e      state_q, state_d;
    logic [TCW-1:0] tcnt_q, tcnt_d;
    logic [2:0]     bit_q, bit_d;
    logic [7:0]     shift_q, shift_d;
    logic           bit_end;

    assign bit_end = tick && (tcnt_q == LAST_TICK);

    // next state
    always_comb begin
        state_d = state_q;
        tcnt_d  = tcnt_q;
        bit_d   = bit_q;
        shift_d = shift_q;
        if (state_q != TX_IDLE && tick) tcnt_d = tcnt_q + 1'b1;
        unique case (state_q)
            TX_IDLE: begin
                if (!q_empty) begin
                    state_d = TX_START;
                    shift_d = q_data;
                    tcnt_d  = '0;
                end
            end
            TX_START: begin
                if (bit_end) begin
                    state_d = TX_DATA;
                    bit_d   = '0;
                end
            end
            TX_DATA: begin
                if (bit_end) begin
                    shift_d = {1'b0, shift_q[7:1]};
                    if (bit_q == 3'd7) state_d = TX_STOP;
                    else               bit_d   = bit_q + 1'b1;
                end
            end
            TX_STOP: begin
                if (bit_end) state_d = TX_IDLE;
            end
            default: state_d = TX_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            tcnt_q  <= '0;
            bit_q   <= '0;
            shift_q <= '0;
        end else begin
            state_q <= state_d;
            tcnt_q  <= tcnt_d;
            bit_q   <= bit_d;
            shift_q <= shift_d;
        end
    end

    // outputs
    always_comb begin
        q_pop = 1'b0;
        line  = 1'b1;
        unique case (state_q)
            TX_IDLE:  q_pop = !q_empty;
            TX_START: line  = 1'b0;
            TX_DATA:  line  = shift_q[0];
            TX_STOP:  line  = 1'b1;
            default:  line  = 1'b1;
        endcase
    end

    AST_TX_POP_STARTS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        q_pop |=> (!line && state_q == TX_START));                           // R3

endmodule

// File: rtl/spc_rx.sv
module spc_rx
    import spc_pkg::*;
#(
    parameter int TICKS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       line_in,
    output logic       byte_valid,
    output logic [7:0] byte_data,
    output logic       stop_bad
);
    localparam int TCW = $clog2(TICKS);
    localparam logic [TCW-1:0] LAST_TICK = TCW'(TICKS - 1);
    localparam logic [TCW-1:0] MID_TICK  = TCW'(TICKS / 2 - 1);

    rx_state_e      state_q, state_d;
    logic [TCW-1:0] tcnt_q, tcnt_d;
    logic [2:0]     bit_q, bit_d;
    logic [7:0]     shift_q, shift_d;
    logic [1:0]     sync_q;
    logic           line_s, bit_end;

    assign line_s  = sync_q[1];
    assign bit_end = tick && (tcnt_q == LAST_TICK);

    // next state
    always_comb begin
        state_d = state_q;
        tcnt_d  = tcnt_q;
        bit_d   = bit_q;
        shift_d = shift_q;
        if (tick) tcnt_d = tcnt_q + 1'b1;
        unique case (state_q)
            RX_IDLE: begin
                tcnt_d = '0;
                if (!line_s) state_d = RX_START;
            end
            RX_START: begin
                if (tick && tcnt_q == MID_TICK) begin
                    tcnt_d = '0;
                    bit_d  = '0;
                    state_d = line_s ? RX_IDLE : RX_DATA;
                end
            end
            RX_DATA: begin
                if (bit_end) begin
                    shift_d = {line_s, shift_q[7:1]};
                    if (bit_q == 3'd7) state_d = RX_STOP;
                    else               bit_d   = bit_q + 1'b1;
                end
            end
            RX_STOP: begin
                if (bit_end) state_d = line_s ? RX_IDLE : RX_WAIT_HIGH;
            end
            RX_WAIT_HIGH: begin
                if (line_s) state_d = RX_IDLE;
            end
            default: state_d = RX_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            tcnt_q  <= '0;
            bit_q   <= '0;
            shift_q <= '0;
            sync_q  <= 2'b11;
        end else begin
            state_q <= state_d;
            tcnt_q  <= tcnt_d;
            bit_q   <= bit_d;
            shift_q <= shift_d;
            sync_q  <= {sync_q[0], line_in};
        end
    end

    // outputs
    always_comb begin
        byte_valid = 1'b0;
        stop_bad   = 1'b0;
        unique case (state_q)
            RX_STOP: begin
                byte_valid = bit_end;
                stop_bad   = bit_end && !line_s;
            end
            default: begin
                byte_valid = 1'b0;
                stop_bad   = 1'b0;
            end
        endcase
    end
    assign byte_data = shift_q;

    AST_RX_BAD_STOP_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_bad |=> (state_q == RX_WAIT_HIGH));                             // R7

endmodule

// File: rtl/serial_port_ctrl.sv
module serial_port_ctrl
    import spc_pkg::*;
#(
    parameter int CLK_DIV    = 4,
    parameter int OVERSAMPLE = 16,
    parameter int FIFO_DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_en,
    input  logic        bus_we,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    input  logic        ser_rx,
    output logic        ser_tx
);
    logic [1:0] word;
    logic       rd_rx, wr_tx, rd_st, wr_ct;
    logic       tick;
    logic       tx_full, tx_empty, tx_pop;
    logic [7:0] tx_data;
    logic       rx_full, rx_empty, rx_valid, rx_stop_bad;
    logic [7:0] rx_byte, rx_head;
    logic       ie_q, err_frame_q, err_ovr_q, tx_pend_q, tx_empty_q;
    logic       ovr_event;
    logic [7:0] status;
    logic       unused_bits;

    assign unused_bits = ^{bus_wdata[31:8], bus_addr[1:0]};

    // register decode
    assign word  = bus_addr[3:2];
    assign rd_rx = bus_en && !bus_we && (word == WORD_RXDATA);
    assign wr_tx = bus_en &&  bus_we && (word == WORD_TXDATA);
    assign rd_st = bus_en && !bus_we && (word == WORD_STATUS);
    assign wr_ct = bus_en &&  bus_we && (word == WORD_CONTROL);

    // oversample tick
    generate
        if (CLK_DIV > 1) begin : g_prescale
            localparam int PW = $clog2(CLK_DIV);
            logic [PW-1:0] pre_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                          pre_q <= '0;
                else if (pre_q == PW'(CLK_DIV - 1))  pre_q <= '0;
                else                                 pre_q <= pre_q + 1'b1;
            end
            assign tick = (pre_q == PW'(CLK_DIV - 1));
        end else begin : g_no_prescale
            assign tick = 1'b1;
        end
    endgenerate

    spc_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (wr_ct && bus_wdata[CTL_TX_CLR]),
        .push  (wr_tx),
        .wdata (bus_wdata[7:0]),
        .pop   (tx_pop),
        .rdata (tx_data),
        .full  (tx_full),
        .empty (tx_empty)
    );

    spc_tx #(.TICKS(OVERSAMPLE)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .q_empty (tx_empty),
        .q_data  (tx_data),
        .q_pop   (tx_pop),
        .line    (ser_tx)
    );

    spc_rx #(.TICKS(OVERSAMPLE)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .line_in    (ser_rx),
        .byte_valid (rx_valid),
        .byte_data  (rx_byte),
        .stop_bad   (rx_stop_bad)
    );

    spc_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (wr_ct && bus_wdata[CTL_RX_CLR]),
        .push  (rx_valid),
        .wdata (rx_byte),
        .pop   (rd_rx),
        .rdata (rx_head),
        .full  (rx_full),
        .empty (rx_empty)
    );

    assign ovr_event = rx_valid && rx_full && !rd_rx;

    // flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q        <= 1'b0;
            err_frame_q <= 1'b0;
            err_ovr_q   <= 1'b0;
            tx_pend_q   <= 1'b0;
            tx_empty_q  <= 1'b1;
        end else begin
            if (wr_ct) ie_q <= bus_wdata[CTL_IE];
            err_frame_q <= rx_stop_bad || (err_frame_q && !rd_st);
            err_ovr_q   <= ovr_event   || (err_ovr_q   && !rd_st);
            tx_empty_q  <= tx_empty;
            tx_pend_q   <= (tx_empty && !tx_empty_q) ||
                           (tx_pend_q && !(wr_tx || rd_st));
        end
    end

    assign status = {1'b0, err_frame_q, err_ovr_q, ie_q,
                     tx_full, tx_empty, rx_full, !rx_empty};

    always_comb begin
        bus_rdata = '0;
        if (rd_rx && !rx_empty) bus_rdata = {24'd0, rx_head};
        else if (rd_st)         bus_rdata = {24'd0, status};
    end

    assign irq = ie_q && (!rx_empty || tx_pend_q);

    AST_OVERRUN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_event |=> err_ovr_q);                                            // R6
    AST_STATUS_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_st && !rx_stop_bad && !ovr_event) |=> (!err_frame_q && !err_ovr_q)); // R8
    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rx && rx_empty) |-> (bus_rdata == 32'd0));                       // R9
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ie_q && !(wr_ct && bus_wdata[CTL_IE])) |=> !irq);                  // R12

endmodule

// File: tb/serial_port_ctrl_tb_top.sv
module serial_port_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_DIV    = 4;
    localparam int BIT_CLKS   = 16 * CLK_DIV;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        ser_rx = 1'b1;
    logic        ser_tx;

    int n_checks = 0;
    int n_fails  = 0;

    // reference model state
    logic [7:0] m_rxq[$];
    logic [7:0] tx_seen[$];
    bit m_fr = 0, m_ovr = 0, m_ie = 0;

    serial_port_ctrl #(.CLK_DIV(CLK_DIV), .OVERSAMPLE(16), .FIFO_DEPTH(16)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq),
        .ser_rx    (ser_rx),
        .ser_tx    (ser_tx)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    endtask

    task automatic bus_write(input int idx, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = 4'(idx << 2); bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input int idx, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = 4'(idx << 2);
        #1 d = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    function automatic logic [31:0] model_status(input bit txfull, input bit txempty);
        return {24'd0, 1'b0, m_fr, m_ovr, m_ie, txfull, txempty,
                (m_rxq.size() == 16), (m_rxq.size() > 0)};
    endfunction

    task automatic read_status(input string req, input bit txfull, input bit txempty);
        logic [31:0] d, e;
        e = model_status(txfull, txempty);
        bus_read(2, d);
        chk(d == e, req, "status", d, e);
        m_fr = 0; m_ovr = 0;
    endtask

    task automatic read_rx(input string req);
        logic [31:0] d, e;
        e = (m_rxq.size() > 0) ? {24'd0, m_rxq[0]} : 32'd0;
        bus_read(0, d);
        chk(d == e, req, "rx data", d, e);
        if (m_rxq.size() > 0) void'(m_rxq.pop_front());
    endtask

    task automatic send_frame(input logic [7:0] b, input bit stop_ok);
        @(negedge clk); ser_rx = 1'b0;
        repeat (BIT_CLKS) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            ser_rx = b[i];
            repeat (BIT_CLKS) @(negedge clk);
        end
        ser_rx = stop_ok;
        repeat (BIT_CLKS) @(negedge clk);
        ser_rx = 1'b1;
        repeat (BIT_CLKS) @(negedge clk);
        if (m_rxq.size() < 16) m_rxq.push_back(b);
        else m_ovr = 1;
        if (!stop_ok) m_fr = 1;
    endtask

    task automatic wait_frames(input int n);
        repeat (n * 10 * BIT_CLKS + BIT_CLKS) @(negedge clk);
    endtask

    // line decoder for ser_tx (R3)
    initial begin
        forever begin
            logic [7:0] b;
            @(negedge ser_tx);
            repeat (BIT_CLKS/2) @(negedge clk);
            chk(ser_tx == 1'b0, "R3", "start bit mid", ser_tx, 0);
            for (int i = 0; i < 8; i++) begin
                repeat (BIT_CLKS) @(negedge clk);
                b[i] = ser_tx;
            end
            repeat (BIT_CLKS) @(negedge clk);
            chk(ser_tx == 1'b1, "R3", "stop bit mid", ser_tx, 1);
            tx_seen.push_back(b);
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(irq == 1'b0, "R1", "irq after reset", irq, 0);
        chk(ser_tx == 1'b1, "R1", "ser_tx after reset", ser_tx, 1);
        read_status("R1", 0, 1);
        bus_read(3, d);
        chk(d == 0, "R2", "control reads zero", d, 0);

        // R3 single byte, upper bits ignored
        bus_write(1, 32'h0000_01A5);
        wait_frames(1);
        chk(tx_seen.size() == 1, "R3", "frames sent", tx_seen.size(), 1);
        if (tx_seen.size() > 0) chk(tx_seen[0] == 8'hA5, "R3", "tx byte", tx_seen[0], 8'hA5);
        tx_seen.delete();
        read_status("R4", 0, 1);

        // R4 fill transmit queue, one write too many
        for (int i = 0; i < 18; i++) bus_write(1, 32'(8'h40 + i));
        read_status("R4", 1, 0);
        wait_frames(17);
        chk(tx_seen.size() == 17, "R4", "bytes sent after overfill", tx_seen.size(), 17);
        for (int i = 0; i < 17 && i < tx_seen.size(); i++)
            chk(tx_seen[i] == 8'(8'h40 + i), "R3", "tx order", tx_seen[i], 8'h40 + i);
        tx_seen.delete();
        read_status("R4", 0, 1);

        // R5 receive one byte
        send_frame(8'hA5, 1);
        read_status("R5", 0, 1);
        read_rx("R5");
        read_status("R5", 0, 1);
        // R9 empty read
        read_rx("R9");
        read_status("R9", 0, 1);

        // R6 overrun
        for (int i = 0; i < 17; i++) send_frame(8'(i * 7 + 3), 1);
        read_status("R6", 0, 1);
        read_status("R8", 0, 1);
        for (int i = 0; i < 16; i++) read_rx("R6");
        read_status("R6", 0, 1);

        // R7 framing error
        send_frame(8'h3C, 0);
        read_status("R7", 0, 1);
        read_status("R8", 0, 1);
        read_rx("R7");

        // R10 queue clears
        send_frame(8'h11, 1);
        send_frame(8'h22, 1);
        bus_write(3, 32'h0000_0002);
        m_rxq.delete();
        read_status("R10", 0, 1);
        for (int i = 0; i < 5; i++) bus_write(1, 32'(8'h90 + i));
        bus_write(3, 32'h0000_0001);
        read_status("R10", 0, 1);
        wait_frames(3);
        chk(tx_seen.size() == 1, "R10", "frames after tx clear", tx_seen.size(), 1);
        if (tx_seen.size() > 0) chk(tx_seen[0] == 8'h90, "R10", "in-flight byte", tx_seen[0], 8'h90);
        tx_seen.delete();

        // R11 / R12 interrupt
        bus_write(3, 32'h0000_0010);
        m_ie = 1;
        read_status("R11", 0, 1);
        @(negedge clk);
        chk(irq == 1'b0, "R12", "irq idle", irq, 0);
        send_frame(8'h5A, 1);
        chk(irq == 1'b1, "R12", "irq on rx data", irq, 1);
        read_rx("R12");
        @(negedge clk);
        chk(irq == 1'b0, "R12", "irq after drain", irq, 0);
        bus_write(1, 32'h0000_0055);
        repeat (4) @(negedge clk);
        chk(irq == 1'b1, "R12", "irq on tx empty", irq, 1);
        read_status("R12", 0, 1);
        @(negedge clk);
        chk(irq == 1'b0, "R12", "irq after status read", irq, 0);
        wait_frames(1);
        chk(tx_seen.size() == 1, "R3", "irq test frame", tx_seen.size(), 1);
        tx_seen.delete();

        // R2 status is read-only
        bus_write(2, 32'h0000_00FF);
        read_status("R2", 0, 1);
        bus_read(3, d);
        chk(d == 0, "R2", "control reads zero", d, 0);
        chk(irq == 1'b0, "R2", "irq after status write", irq, 0);

        finish_run();
    end

endmodule